// File: doc/BRIEF.md
# I/O Register Space Access Unit

This block sits between a small 8-bit processor core and the register space of its peripherals. Each cycle it may take one request made of an operation code, a 9-bit address, a 3-bit bit index and a data byte. It translates the request into a single unified data-space address, checks that the operation may reach that address, and then returns read data, raises a skip decision for a bit test, or schedules a write. An illegal request raises a one-cycle error and changes nothing.

The map holds three scratch registers for software, one flag register and one extended scratch register. Software clears a flag by writing one to it, and hardware sets flags through a dedicated input. The short form reaches I/O addresses 0x00 to 0x3F at data address I/O plus 0x20. The bit-level forms reach only I/O addresses 0x00 to 0x1F. The extended space, data addresses 0x60 to 0x1FF, can be reached only by data-space loads and stores. Each request passes through an action classification (idle, read, write, set bit, clear bit, test-for-set, test-for-clear, fault), and that classification drives every output. The block keeps no sequencing state between requests.

Top module: `io_access_unit`

## Requirements
- R1: Operation codes are 0 short read, 1 short write, 2 data load, 3 data store, 4 set bit, 5 clear bit, 6 skip-if-set test and 7 skip-if-clear test. A short read or write to I/O address A (0x00..0x3F) reaches data address A+0x20, which is the same register a data load or store at A+0x20 reaches. A short access above 0x3F is illegal.
- R2: Set-bit, clear-bit and both test operations are legal only for I/O addresses 0x00 to 0x1F. Above that they are illegal.
- R3: The extended scratch register at data address 0x100 is reachable by data load and store. A short access at address 0x100 is illegal.
- R4: A data load or store to a data address below 0x20 is illegal.
- R5: An illegal request (valid and in violation of R1, R2 or R4) drives `err` high in the same cycle, returns zero read data and no skip, and leaves every register unchanged.
- R6: The flag register sits at I/O 0x05 (data 0x25) and its default implemented bits are 0x0F. A full-byte write clears each flag whose written bit is one and leaves the flags written with zero alone.
- R7: Set-bit on the flag register clears only the named flag. Clear-bit on the flag register has no effect.
- R8: The scratch registers sit at I/O 0x03, 0x04 (bit-accessible) and 0x25 (data 0x23, 0x24, 0x45). Set-bit and clear-bit change only the named bit of a scratch register.
- R9: A test operation returns the register on `rd_data`. `skip` is the tested bit for op 6 and its inverse for op 7. `skip` is low for every other operation.
- R10: A nonzero bit of `hw_flag_set` sets the matching implemented flag at the next edge, and it wins over a software clear of that flag in the same cycle.
- R11: Writes to unmapped addresses have no effect, and reads of them return zero. Flag bits outside the implemented mask always read zero.
- R12: After reset every register reads zero.
- R13: Reads are combinational in the request cycle. Writes become visible at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 9 | I/O address for short and bit forms, data address for load/store |
| req_bit | input | 3 | Bit index for bit set/clear/test |
| req_wdata | input | 8 | Write data for short write and data store |
| hw_flag_set | input | 8 | Hardware flag set pulses, one per flag bit |
| rd_data | output | 8 | Read data for reads and tests, zero otherwise |
| skip | output | 1 | Skip decision of a test operation |
| err | output | 1 | Illegal request pulse |

## Verification
The stateful properties assume that `hw_flag_set` is zero in the cycle they examine, so they are conditioned on that and say nothing about cycles where hardware also sets flags. They also assume that inputs are known once reset is released. The random stimulus keeps hardware set pulses sparse so that those conditioned windows occur often. It draws addresses mostly from the mapped registers and the edges of the three address views (0x1F, 0x20, 0x3F, 0x40, 0x100), so that both legal and illegal combinations come up for every operation.

// File: rtl/io_pkg.sv
package io_pkg;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int GP_N   = 3;
    localparam logic [ADDR_W-1:0] IO_OFS = 9'h020;

    typedef enum logic [2:0] {
        OP_IN   = 3'd0,
        OP_OUT  = 3'd1,
        OP_LD   = 3'd2,
        OP_ST   = 3'd3,
        OP_BSET = 3'd4,
        OP_BCLR = 3'd5,
        OP_SKS  = 3'd6,
        OP_SKC  = 3'd7
    } io_op_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_READ,
        ACT_WRITE,
        ACT_BSET,
        ACT_BCLR,
        ACT_TSET,
        ACT_TCLR,
        ACT_FAULT
    } io_act_e;
endpackage

// File: rtl/io_req_decode.sv
module io_req_decode
    import io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SHORT_LAST = 9'h03F,
    parameter logic [ADDR_W-1:0] BIT_LAST   = 9'h01F
) (
    input  logic              valid,
    input  io_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    output io_act_e           act,
    output logic [ADDR_W-1:0] daddr
);
    logic short_ok, bit_ok, data_ok;

    assign short_ok = (addr <= SHORT_LAST);
    assign bit_ok   = (addr <= BIT_LAST);
    assign data_ok  = (addr >= IO_OFS);

    always_comb begin
        daddr = addr + IO_OFS;
        act   = ACT_IDLE;
        if (valid) begin
            unique case (op)
                OP_IN:   act = short_ok ? ACT_READ  : ACT_FAULT;
                OP_OUT:  act = short_ok ? ACT_WRITE : ACT_FAULT;
                OP_LD: begin
                    daddr = addr;
                    act   = data_ok ? ACT_READ : ACT_FAULT;
                end
                OP_ST: begin
                    daddr = addr;
                    act   = data_ok ? ACT_WRITE : ACT_FAULT;
                end
                OP_BSET: act = bit_ok ? ACT_BSET : ACT_FAULT;
                OP_BCLR: act = bit_ok ? ACT_BCLR : ACT_FAULT;
                OP_SKS:  act = bit_ok ? ACT_TSET : ACT_FAULT;
                OP_SKC:  act = bit_ok ? ACT_TCLR : ACT_FAULT;
                default: act = ACT_FAULT;
            endcase
        end
    end
endmodule

// File: rtl/io_reg_bank.sv
module io_reg_bank
    import io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GP_DA [GP_N] = '{9'h023, 9'h024, 9'h045},
    parameter logic [ADDR_W-1:0] STAT_DA      = 9'h025,
    parameter logic [ADDR_W-1:0] EXT_DA       = 9'h100,
    parameter logic [DATA_W-1:0] STAT_MASK    = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  io_act_e           act,
    input  logic [ADDR_W-1:0] daddr,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] stat_flags
);
    logic [DATA_W-1:0]            bit_mask;
    logic [GP_N-1:0][DATA_W-1:0]  gp_q;
    logic [DATA_W-1:0]            stat_q, stat_clr, ext_q;

    assign bit_mask = DATA_W'(1) << bit_idx;

    for (genvar g = 0; g < GP_N; g++) begin : g_gp
        logic [DATA_W-1:0] gp_r;
        logic              hit;
        assign hit = (daddr == GP_DA[g]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gp_r <= '0;
            end else if (hit) begin
                unique case (act)
                    ACT_WRITE: gp_r <= wdata;
                    ACT_BSET:  gp_r <= gp_r | bit_mask;
                    ACT_BCLR:  gp_r <= gp_r & ~bit_mask;
                    default:   gp_r <= gp_r;
                endcase
            end
        end
        assign gp_q[g] = gp_r;
    end

    always_comb begin
        stat_clr = '0;
        if (daddr == STAT_DA) begin
            unique case (act)
                ACT_WRITE: stat_clr = wdata;
                ACT_BSET:  stat_clr = bit_mask;
                default:   stat_clr = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~stat_clr) | hw_set) & STAT_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (act == ACT_WRITE && daddr == EXT_DA) begin
            ext_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < GP_N; g++) begin
            if (daddr == GP_DA[g]) rdata = gp_q[g];
        end
        if (daddr == STAT_DA) rdata = stat_q;
        if (daddr == EXT_DA)  rdata = ext_q;
    end

    assign stat_flags = stat_q;
endmodule

// File: rtl/io_access_unit.sv
module io_access_unit
    import io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] GP0_DA    = 9'h023,
    parameter logic [ADDR_W-1:0] GP1_DA    = 9'h024,
    parameter logic [ADDR_W-1:0] GP2_DA    = 9'h045,
    parameter logic [ADDR_W-1:0] STAT_DA   = 9'h025,
    parameter logic [ADDR_W-1:0] EXT_DA    = 9'h100,
    parameter logic [DATA_W-1:0] STAT_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BIT_W-1:0]  req_bit,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] hw_flag_set,
    output logic [DATA_W-1:0] rd_data,
    output logic              skip,
    output logic              err
);
    io_act_e           act;
    logic [ADDR_W-1:0] daddr;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] stat_flags;
    logic [DATA_W-1:0] hw_masked;

    assign hw_masked = hw_flag_set & STAT_MASK;

    io_req_decode u_dec (
        .valid (req_valid),
        .op    (io_op_e'(req_op)),
        .addr  (req_addr),
        .act   (act),
        .daddr (daddr)
    );

    io_reg_bank #(
        .GP_DA     ('{GP0_DA, GP1_DA, GP2_DA}),
        .STAT_DA   (STAT_DA),
        .EXT_DA    (EXT_DA),
        .STAT_MASK (STAT_MASK)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .daddr      (daddr),
        .bit_idx    (req_bit),
        .wdata      (req_wdata),
        .hw_set     (hw_masked),
        .rdata      (bank_rd),
        .stat_flags (stat_flags)
    );

    always_comb begin
        rd_data = '0;
        skip    = 1'b0;
        err     = 1'b0;
        unique case (act)
            ACT_READ:  rd_data = bank_rd;
            ACT_TSET: begin
                rd_data = bank_rd;
                skip    = bank_rd[req_bit];
            end
            ACT_TCLR: begin
                rd_data = bank_rd;
                skip    = ~bank_rd[req_bit];
            end
            ACT_FAULT: err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/io_access_chk.sv
module io_access_chk
    import io_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_DA   = 9'h025,
    parameter logic [DATA_W-1:0] STAT_MASK = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BIT_W-1:0]  req_bit,
    input logic [DATA_W-1:0] hw_flag_set,
    input logic [DATA_W-1:0] rd_data,
    input logic              skip,
    input logic              err,
    input logic [DATA_W-1:0] stat_flags
);
    localparam logic [ADDR_W-1:0] STAT_IO = STAT_DA - IO_OFS;

    logic [DATA_W-1:0] hw_m;
    logic              short_op, bit_op;
    assign hw_m     = hw_flag_set & STAT_MASK;
    assign short_op = (req_op == OP_IN) || (req_op == OP_OUT);
    assign bit_op   = (req_op >= OP_BSET);

    // R1
    short_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && short_op && req_addr > 9'h03F) |-> err);

    // R2
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bit_op && req_addr > 9'h01F) |-> err);

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && hw_m == '0) |=> $stable(stat_flags));

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!skip && rd_data == '0));

    // R7
    bset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_BSET && req_addr == STAT_IO && hw_m == '0)
        |=> stat_flags == ($past(stat_flags) & ~(DATA_W'(1) << $past(req_bit))));

    // R9
    skip_only_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (req_valid && (req_op == OP_SKS || req_op == OP_SKC)));

    // R10
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_m != '0) |=> ((stat_flags & $past(hw_m)) == $past(hw_m)));

    // R11
    flag_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_IN && req_addr == STAT_IO)
        |-> ((rd_data & ~STAT_MASK) == '0));
endmodule

bind io_access_unit io_access_chk #(
    .STAT_DA   (STAT_DA),
    .STAT_MASK (STAT_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_bit     (req_bit),
    .hw_flag_set (hw_flag_set),
    .rd_data     (rd_data),
    .skip        (skip),
    .err         (err),
    .stat_flags  (stat_flags)
);

// File: tb/sim_io_access_unit.sv
module sim_io_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] MASK = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [8:0] req_addr = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] hw_flag_set = '0;
    logic [7:0] rd_data;
    logic       skip;
    logic       err;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_gp0 = 0, m_gp1 = 0, m_gp2 = 0, m_stat = 0, m_ext = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_access_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
        .hw_flag_set(hw_flag_set), .rd_data(rd_data), .skip(skip), .err(err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [8:0] da);
        case (da)
            9'h023:  return m_gp0;
            9'h024:  return m_gp1;
            9'h045:  return m_gp2;
            9'h025:  return m_stat;
            9'h100:  return m_ext;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_illegal(input logic [2:0] op, input logic [8:0] a);
        if (op <= 3'd1) return a > 9'h03F;
        if (op <= 3'd3) return a < 9'h020;
        return a > 9'h01F;
    endfunction

    task automatic do_req(input string tag, input logic v, input logic [2:0] op,
                          input logic [8:0] a, input logic [2:0] b,
                          input logic [7:0] wd, input logic [7:0] hw);
        logic [8:0] da;
        logic       e_err, e_skip;
        logic [7:0] e_rd, cur, clr;
        @(negedge clk);
        req_valid = v; req_op = op; req_addr = a; req_bit = b;
        req_wdata = wd; hw_flag_set = hw;
        #1;
        da     = (op == 3'd2 || op == 3'd3) ? a : a + 9'h020;
        e_err  = v && is_illegal(op, a);
        cur    = model_rd(da);
        e_rd   = 8'h00;
        e_skip = 1'b0;
        if (v && !e_err) begin
            if (op == 3'd0 || op == 3'd2 || op >= 3'd6) e_rd = cur;
            if (op == 3'd6) e_skip = cur[b];
            if (op == 3'd7) e_skip = ~cur[b];
        end
        chk(tag, "rd_data", rd_data, e_rd);
        chk(tag, "skip", skip, e_skip);
        chk(tag, "err", err, e_err);
        @(posedge clk);
        clr = 8'h00;
        if (v && !e_err) begin
            if (op == 3'd1 || op == 3'd3) begin
                case (da)
                    9'h023: m_gp0 = wd;
                    9'h024: m_gp1 = wd;
                    9'h045: m_gp2 = wd;
                    9'h025: clr = wd;
                    9'h100: m_ext = wd;
                    default: ;
                endcase
            end else if (op == 3'd4) begin
                case (da)
                    9'h023: m_gp0[b] = 1'b1;
                    9'h024: m_gp1[b] = 1'b1;
                    9'h025: clr[b] = 1'b1;
                    default: ;
                endcase
            end else if (op == 3'd5) begin
                case (da)
                    9'h023: m_gp0[b] = 1'b0;
                    9'h024: m_gp1[b] = 1'b0;
                    default: ;
                endcase
            end
        end
        m_stat = ((m_stat & ~clr) | hw) & MASK;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        do_req("R12", 1, 3'd0, 9'h003, 0, 0, 0);
        do_req("R12", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R12", 1, 3'd0, 9'h025, 0, 0, 0);
        do_req("R12", 1, 3'd2, 9'h100, 0, 0, 0);
        // R1 short view and data view alias
        do_req("R1", 1, 3'd1, 9'h003, 0, 8'hA5, 0);
        do_req("R13", 1, 3'd0, 9'h003, 0, 0, 0);
        do_req("R1", 1, 3'd2, 9'h023, 0, 0, 0);
        do_req("R1", 1, 3'd3, 9'h045, 0, 8'h3C, 0);
        do_req("R1", 1, 3'd0, 9'h025, 0, 0, 0);
        do_req("R1", 1, 3'd0, 9'h040, 0, 0, 0);
        // R3 extended register
        do_req("R3", 1, 3'd3, 9'h100, 0, 8'h77, 0);
        do_req("R3", 1, 3'd2, 9'h100, 0, 0, 0);
        do_req("R3", 1, 3'd0, 9'h100, 0, 0, 0);
        do_req("R3", 1, 3'd1, 9'h100, 0, 8'h11, 0);
        do_req("R3", 1, 3'd2, 9'h100, 0, 0, 0);
        // R10 hardware set, R7 bit ops on flags, R6 full write
        do_req("R10", 0, 3'd0, 9'h000, 0, 0, 8'h0F);
        do_req("R10", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R7", 1, 3'd4, 9'h005, 3'd1, 0, 0);
        do_req("R7", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R7", 1, 3'd5, 9'h005, 3'd0, 0, 0);
        do_req("R7", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R6", 1, 3'd1, 9'h005, 0, 8'h04, 0);
        do_req("R6", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R10", 1, 3'd1, 9'h005, 0, 8'h01, 8'h01);
        do_req("R10", 1, 3'd0, 9'h005, 0, 0, 0);
        // R11 reserved flag bits and unmapped addresses
        do_req("R11", 0, 3'd0, 9'h000, 0, 0, 8'hF0);
        do_req("R11", 1, 3'd0, 9'h005, 0, 0, 0);
        do_req("R11", 1, 3'd1, 9'h010, 0, 8'hFF, 0);
        do_req("R11", 1, 3'd0, 9'h010, 0, 0, 0);
        do_req("R11", 1, 3'd3, 9'h150, 0, 8'hFF, 0);
        do_req("R11", 1, 3'd2, 9'h150, 0, 0, 0);
        // R8 bit ops on scratch
        do_req("R8", 1, 3'd4, 9'h003, 3'd6, 0, 0);
        do_req("R8", 1, 3'd0, 9'h003, 0, 0, 0);
        do_req("R8", 1, 3'd5, 9'h003, 3'd0, 0, 0);
        do_req("R8", 1, 3'd0, 9'h003, 0, 0, 0);
        do_req("R8", 1, 3'd4, 9'h004, 3'd7, 0, 0);
        do_req("R8", 1, 3'd0, 9'h004, 0, 0, 0);
        // R9 skip tests
        do_req("R9", 1, 3'd6, 9'h003, 3'd2, 0, 0);
        do_req("R9", 1, 3'd7, 9'h003, 3'd2, 0, 0);
        do_req("R9", 1, 3'd6, 9'h003, 3'd3, 0, 0);
        do_req("R9", 1, 3'd7, 9'h003, 3'd3, 0, 0);
        // R2 / R5 illegal bit ops leave state
        do_req("R2", 1, 3'd4, 9'h020, 3'd0, 0, 0);
        do_req("R2", 1, 3'd4, 9'h025, 3'd0, 0, 0);
        do_req("R5", 1, 3'd0, 9'h025, 0, 0, 0);
        do_req("R2", 1, 3'd6, 9'h025, 3'd2, 0, 0);
        // R4 / R5 working-register range
        do_req("R4", 1, 3'd2, 9'h01F, 0, 0, 0);
        do_req("R4", 1, 3'd3, 9'h003, 0, 8'hFF, 0);
        do_req("R5", 1, 3'd0, 9'h003, 0, 0, 0);
        do_req("R5", 1, 3'd1, 9'h043, 0, 8'h00, 0);
        do_req("R5", 1, 3'd0, 9'h003, 0, 0, 0);

        // R13 random mix
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1500; i++) begin
            logic [8:0] a;
            logic [7:0] hw;
            case ($urandom % 14)
                0: a = 9'h003;  1: a = 9'h004;  2: a = 9'h005;  3: a = 9'h025;
                4: a = 9'h023;  5: a = 9'h024;  6: a = 9'h045;  7: a = 9'h100;
                8: a = 9'h01F;  9: a = 9'h020; 10: a = 9'h03F; 11: a = 9'h040;
                default: a = 9'($urandom);
            endcase
            hw = (($urandom % 5) == 0) ? 8'($urandom) : 8'h00;
            do_req("R13", ($urandom % 8) != 0, 3'($urandom), a, 3'($urandom),
                   8'($urandom), hw);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule